// File: doc/BRIEF.md
# Cascaded Delta-Sigma ADC Chain Reader

This block sits between a serial port wired to a chain of cascaded 8-channel, 24-bit delta-sigma converters and a FIFO write port that leads into a faster clock domain. The converters are daisy-chained. Each device passes its conversion data into the daisy input of its neighbour, so the whole chain appears on the data output of the device closest to the logic. The block waits for the active-low data-ready line to fall. It then holds chip select low and clocks out one full chain frame in SPI mode 1.

As the frame arrives, the block cuts it into 24-bit words. In each device segment it discards the leading status word and forwards the eight channel words as separate samples. Each sample carries a global channel number. A sample is written to the FIFO only when the FIFO reports space. A sample that finds the FIFO full is lost, and a sticky overflow flag records the loss. A small command path shifts a 24-bit register-write word out on the serial data input, so the same port both configures and reads the converters. The number of cascaded devices is a parameter.

Top module: `daisy_adc_reader`

## Requirements
- R1: After reset, chip select is high, SCLK is low, the serial data output to the converters is low, no FIFO write is issued, the overflow flag is clear and the command path is ready.
- R2: A falling edge on the active-low data-ready input starts a read within a few clock cycles. During the read, chip select stays low for exactly 216 × NDEV SCLK rising edges. SCLK idles low, data is sampled on the SCLK falling edge, and the converters drive it on the rising edge.
- R3: Each device segment is nine 24-bit words, received MSB first. Word 0 is the status word and is never forwarded. Words 1 to 8 are forwarded unchanged as 24-bit samples.
- R4: Each forwarded sample carries channel number device × 8 + (word − 1). Device 0 is the first segment to arrive. The numbers therefore run from 0 to 8 × NDEV − 1 in arrival order.
- R5: A sample is written to the FIFO, as a one-cycle write-enable pulse, only if the FIFO full input is low on the clock edge at which the sample's last bit is taken. Otherwise the sample is discarded.
- R6: A discarded sample sets the overflow flag. The flag then stays set until reset, even after the FIFO drains and later frames are written normally.
- R7: The command path is ready only while no transfer is running and no read is pending. An accepted 24-bit command word is shifted out MSB first, changing on SCLK rising edges, in exactly 24 SCLK pulses under one chip-select window.
- R8: The serial data output to the converters stays low throughout a read.
- R9: A data-ready falling edge that arrives during a command transfer is not lost. The read starts once the command has finished.
- R10: Chip select returns high for at least one clock cycle between transfers, and SCLK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-side clock; SCLK runs at half this rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n | input | 1 | Active-low data-ready from the chain; its falling edge starts a read |
| adc_dout | input | 1 | Chain data stream from the first device |
| sclk | output | 1 | Serial clock to all devices |
| cs_n | output | 1 | Active-low chip select shared by the chain |
| adc_din | output | 1 | Serial command data to the devices |
| cmd_valid | input | 1 | A command word is offered |
| cmd_word | input | 24 | Command word, sent MSB first |
| cmd_ready | output | 1 | Command accepted on a clock edge where this and cmd_valid are high |
| fifo_full | input | 1 | FIFO write side has no space |
| fifo_wr_en | output | 1 | One-cycle write strobe for a sample |
| fifo_wr_data | output | 24 | Sample value |
| fifo_wr_chan | output | $clog2(8×NDEV) | Global channel number of the sample |
| overflow | output | 1 | Sticky flag: a sample was dropped on a full FIFO |

## Verification
The assertions assume that the data-ready line falls only while chip select is high or during a command, never in the middle of a read. They also assume that the converters change their output only on SCLK rising edges, and that the FIFO full input is a level that holds steady between clock edges. The bench models the chain as a shift source that updates on SCLK rising edges. It lowers data-ready and drives every other input only at falling clock edges. It issues a data-ready edge during a read only in the case where one arrives during a command, and it holds FIFO full at a constant level for a whole frame.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned CH_PER_DEV    = 8;
  localparam int unsigned WORD_W        = 24;
  localparam int unsigned WORDS_PER_DEV = CH_PER_DEV + 1;
  localparam int unsigned BITS_PER_DEV  = WORDS_PER_DEV * WORD_W;
  localparam int unsigned CMD_BITS      = 24;

  // total SCLK pulses for one chain frame
  function automatic int unsigned frame_bits(input int unsigned ndev);
    return ndev * BITS_PER_DEV;
  endfunction

  // global channel number of word 'word' (1..8) in device segment 'dev'
  function automatic int unsigned chan_index(input int unsigned dev,
                                             input int unsigned word);
    return dev * CH_PER_DEV + word - 1;
  endfunction
endpackage

// File: rtl/dcr_edge_sync.sv
module dcr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= din_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;

  // R2: one edge on the line gives one start event
  p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dcr_sclk_engine.sv
module dcr_sclk_engine #(
  parameter int CNT_W = 10,
  parameter int SW    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic [SW-1:0]    load_word,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             bit_stb,
  output logic             done,
  output logic             busy
);
  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_TAIL} est_t;

  est_t             st;
  logic             sclk_q, cs_q, mosi_q;
  logic [CNT_W-1:0] left;
  logic [SW-1:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      mosi_q <= 1'b0;
      left   <= '0;
      sh     <= '0;
    end else begin
      unique case (st)
        E_IDLE: if (start) begin
          st     <= E_SHIFT;
          cs_q   <= 1'b0;
          sclk_q <= 1'b0;
          left   <= len;
          sh     <= load_word;
        end
        E_SHIFT: begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            mosi_q <= sh[SW-1];
            sh     <= {sh[SW-2:0], 1'b0};
          end else begin
            sclk_q <= 1'b0;
            left   <= left - 1'b1;
            if (left == CNT_W'(1)) st <= E_TAIL;
          end
        end
        E_TAIL: begin
          cs_q   <= 1'b1;
          mosi_q <= 1'b0;
          st     <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign cs_n    = cs_q;
  assign mosi    = mosi_q;
  assign bit_stb = (st == E_SHIFT) && sclk_q;
  assign done    = (st == E_TAIL);
  assign busy    = (st != E_IDLE);

  // R2: SCLK edges only inside a chip-select window
  p_clk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> !cs_q);
  // R10: a transfer starts only from idle, which follows a high chip select
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == E_IDLE) && cs_q);
  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len != '0));
endmodule

// File: rtl/dcr_frame_split.sv
module dcr_frame_split #(
  parameter int NDEV = 4,
  parameter int CHW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           bit_stb,
  input  logic           bit_in,
  input  logic           fifo_full,
  output logic           wr_en,
  output logic [23:0]    wr_data,
  output logic [CHW-1:0] wr_chan,
  output logic           overflow
);
  localparam int DEVW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int LASTW = dcr_pkg::WORDS_PER_DEV - 1;

  logic [4:0]      bit_cnt;
  logic [3:0]      word_cnt;
  logic [DEVW-1:0] dev_cnt;
  logic [22:0]     sh;

  // named internal events
  logic           word_done, is_status, push_now, drop_now;
  logic [CHW-1:0] chan_now;

  assign word_done = bit_stb && (bit_cnt == 5'd23);
  assign is_status = (word_cnt == 4'd0);
  assign push_now  = word_done && !is_status && !fifo_full;
  assign drop_now  = word_done && !is_status && fifo_full;
  assign chan_now  = CHW'(dcr_pkg::chan_index(32'(dev_cnt), 32'(word_cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
      dev_cnt  <= '0;
      sh       <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      wr_chan  <= '0;
      overflow <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (frame_start) begin
        bit_cnt  <= '0;
        word_cnt <= '0;
        dev_cnt  <= '0;
      end else if (bit_stb) begin
        sh <= {sh[21:0], bit_in};
        if (word_done) begin
          bit_cnt <= '0;
          if (word_cnt == 4'(LASTW)) begin
            word_cnt <= '0;
            dev_cnt  <= dev_cnt + 1'b1;
          end else begin
            word_cnt <= word_cnt + 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (push_now) begin
        wr_en   <= 1'b1;
        wr_data <= {sh, bit_in};
        wr_chan <= chan_now;
      end
      if (drop_now) overflow <= 1'b1;
    end
  end

  // R5: never write while the FIFO reported full
  p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(fifo_full));
  // R6: overflow is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R3: a completed status word produces no write
  p_status_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && is_status) |=> !wr_en);
  // R4: channel number stays inside the chain
  p_chan_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_chan) < NDEV * 8));
endmodule

// File: rtl/daisy_adc_reader.sv
module daisy_adc_reader #(
  parameter int NDEV = 4,
  localparam int CHW = $clog2(NDEV * 8)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           drdy_n,
  input  logic           adc_dout,
  output logic           sclk,
  output logic           cs_n,
  output logic           adc_din,
  input  logic           cmd_valid,
  input  logic [23:0]    cmd_word,
  output logic           cmd_ready,
  input  logic           fifo_full,
  output logic           fifo_wr_en,
  output logic [23:0]    fifo_wr_data,
  output logic [CHW-1:0] fifo_wr_chan,
  output logic           overflow
);
  localparam int unsigned FRAME_BITS = dcr_pkg::frame_bits(NDEV);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic             rdy_fall, pend, rd_mode;
  logic             eng_busy, eng_done, bit_stb;
  logic             start_rd, start_cmd;
  logic [CNT_W-1:0] len;
  logic [23:0]      load_word;

  dcr_edge_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n (drdy_n),
    .fall  (rdy_fall)
  );

  assign start_rd  = !eng_busy && pend;
  assign cmd_ready = !eng_busy && !pend;
  assign start_cmd = cmd_ready && cmd_valid;
  assign len       = start_rd ? CNT_W'(FRAME_BITS) : CNT_W'(dcr_pkg::CMD_BITS);
  assign load_word = start_rd ? 24'd0 : cmd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      rd_mode <= 1'b0;
    end else begin
      if (rdy_fall)      pend <= 1'b1;
      else if (start_rd) pend <= 1'b0;
      if (start_rd)       rd_mode <= 1'b1;
      else if (start_cmd) rd_mode <= 1'b0;
    end
  end

  dcr_sclk_engine #(.CNT_W(CNT_W), .SW(24)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_rd || start_cmd),
    .len       (len),
    .load_word (load_word),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (adc_din),
    .bit_stb   (bit_stb),
    .done      (eng_done),
    .busy      (eng_busy)
  );

  dcr_frame_split #(.NDEV(NDEV), .CHW(CHW)) u_split (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (start_rd),
    .bit_stb     (bit_stb && rd_mode),
    .bit_in      (adc_dout),
    .fifo_full   (fifo_full),
    .wr_en       (fifo_wr_en),
    .wr_data     (fifo_wr_data),
    .wr_chan     (fifo_wr_chan),
    .overflow    (overflow)
  );

  // R10: clock parked low outside chip select
  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R7: an accepted command opens a chip-select window next cycle
  p_cmd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cs_n);
  // R8: command line quiet during reads
  p_din_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rd_mode) |-> !adc_din);
  // R9: a finished transfer with a pending read goes straight to the read
  p_pending_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && pend) |=> start_rd);
endmodule

// File: tb/daisy_adc_reader_test.sv
`timescale 1ns/1ps
module daisy_adc_reader_test;
  localparam int CLK_PERIOD = 250;
  localparam int NDEV = 4;
  localparam int CHW  = $clog2(NDEV * 8);
  localparam int FB   = NDEV * 216;

  logic clk = 1'b0, rst_n = 1'b0, drdy_n = 1'b1, adc_dout = 1'b0;
  logic sclk, cs_n, adc_din, cmd_ready, fifo_wr_en, overflow;
  logic cmd_valid = 1'b0, fifo_full = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [23:0] fifo_wr_data;
  logic [CHW-1:0] fifo_wr_chan;

  int checks = 0, errors = 0;
  logic [FB-1:0] frame_vec = '0;
  int ptr = 0, sclk_pulses = 0, din_bits = 0, din_hi = 0;
  logic [23:0] din_cap = '0;
  bit expect_read = 1'b0;
  int exp_chan[$];
  logic [23:0] exp_val[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  daisy_adc_reader #(.NDEV(NDEV)) uut (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .adc_dout(adc_dout),
    .sclk(sclk), .cs_n(cs_n), .adc_din(adc_din),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_wr_chan(fifo_wr_chan),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // chain model: data changes on SCLK rising edge
  always @(negedge cs_n) begin
    ptr = 0; sclk_pulses = 0; din_bits = 0; din_hi = 0;
  end
  always @(posedge sclk) if (!cs_n) begin
    adc_dout <= (ptr < FB) ? frame_vec[FB-1-ptr] : 1'b0;
    ptr = ptr + 1;
    sclk_pulses = sclk_pulses + 1;
  end
  always @(negedge sclk) if (!cs_n) begin
    din_cap = {din_cap[22:0], adc_din};
    din_bits = din_bits + 1;
    if (expect_read && adc_din) din_hi = din_hi + 1;
  end

  // monitor: compare every FIFO write against the scoreboard
  always @(negedge clk) if (rst_n && fifo_wr_en) begin
    if (exp_chan.size() == 0) begin
      check(1'b0, "R5", "unexpected FIFO write", 1, 0);
    end else begin
      int ec;
      logic [23:0] ev;
      ec = exp_chan.pop_front();
      ev = exp_val.pop_front();
      check(int'(fifo_wr_chan) == ec, "R4", "channel number", fifo_wr_chan, ec);
      check(fifo_wr_data == ev, "R3", "sample value", fifo_wr_data, ev);
    end
  end

  function automatic logic [23:0] gen(input int seed, input int dev, input int ch);
    if (seed == 2) return ch[0] ? 24'hFFFFFF : 24'h800001;
    return 24'(seed * 40503 + dev * 32796 + ch * 257 + 24'h5A5A5 + (ch << 19));
  endfunction

  task automatic build_frame(input int seed, input bit push_exp);
    for (int d = 0; d < NDEV; d++) begin
      for (int w = 0; w < 9; w++) begin
        logic [23:0] word;
        word = (w == 0) ? (24'hC00000 | 24'(d)) : gen(seed, d, w - 1);
        frame_vec[FB-1-(d*216+w*24) -: 24] = word;
        if (w > 0 && push_exp) begin
          exp_chan.push_back(d * 8 + w - 1);   // R4 arrival order
          exp_val.push_back(word);
        end
      end
    end
  endtask

  task automatic run_read(input int seed, input bit push_exp);
    int lat;
    build_frame(seed, push_exp);
    expect_read = 1'b1;
    @(negedge clk) drdy_n = 1'b0;
    lat = 0;
    while (cs_n) begin @(negedge clk); lat++; end
    check(lat >= 1 && lat <= 6, "R2", "start latency", lat, 4);
    @(posedge cs_n);
    @(negedge clk) drdy_n = 1'b1;
    check(sclk_pulses == FB, "R2", "SCLK pulses per frame", sclk_pulses, FB);
    check(din_hi == 0, "R8", "command line high during read", din_hi, 0);
    check(cs_n && !sclk, "R10", "idle after frame", {cs_n, sclk}, 2'b10);
    repeat (4) @(negedge clk);
    check(exp_chan.size() == 0, "R3", "samples left unwritten", exp_chan.size(), 0);
  endtask

  task automatic send_cmd(input logic [23:0] w);
    expect_read = 1'b0;
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk) cmd_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    check(sclk == 1'b0 && adc_din == 1'b0, "R1", "sclk/din", {sclk, adc_din}, 0);
    check(!fifo_wr_en && !overflow, "R1", "wr_en/overflow", {fifo_wr_en, overflow}, 0);
    check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);

    // R2 R3 R4: two data patterns
    run_read(1, 1'b1);
    run_read(2, 1'b1);

    // R7: register-write command
    send_cmd(24'h4105A6);
    @(posedge cs_n);
    @(negedge clk);
    check(din_cap == 24'h4105A6, "R7", "shifted command word", din_cap, 24'h4105A6);
    check(din_bits == 24 && sclk_pulses == 24, "R7", "command SCLK pulses", sclk_pulses, 24);
    check(!fifo_wr_en && exp_chan.size() == 0, "R7", "command wrote samples", fifo_wr_en, 0);

    // R9: data-ready during a command is served afterwards
    build_frame(3, 1'b1);
    send_cmd(24'h42F00F);
    repeat (6) @(negedge clk);
    drdy_n = 1'b0;
    check(!cs_n && !cmd_ready, "R7", "ready while busy", cmd_ready, 0);
    @(posedge cs_n);
    check(din_cap == 24'h42F00F, "R9", "command kept intact", din_cap, 24'h42F00F);
    expect_read = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R10", "gap between transfers", cs_n, 1);
    @(negedge cs_n);
    @(posedge cs_n);
    @(negedge clk) drdy_n = 1'b1;
    check(sclk_pulses == FB, "R9", "deferred read length", sclk_pulses, FB);
    check(din_hi == 0, "R8", "command line high during read", din_hi, 0);
    repeat (4) @(negedge clk);
    check(exp_chan.size() == 0, "R9", "deferred samples missing", exp_chan.size(), 0);
    check(overflow == 1'b0, "R6", "overflow before full", overflow, 0);

    // R5 R6: full FIFO drops everything and sets the flag
    fifo_full = 1'b1;
    run_read(4, 1'b0);
    check(overflow == 1'b1, "R6", "overflow after drop", overflow, 1);
    fifo_full = 1'b0;
    run_read(5, 1'b1);
    check(overflow == 1'b1, "R6", "overflow sticky", overflow, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule